// File: doc/BRIEF.md
# Quarter-Phase Bus Clock Generator with Memory-Ready Stretch

This block derives the system bus clock E from a free-running clock that runs at four times the bus rate. Each bus cycle is split into four quarter phases, counted 0 to 3. E is low in quarters 0 and 1 and high in quarters 2 and 3. It toggles with a 50% duty cycle whenever memory is ready.

A slow memory pulls the memory-ready input low to hold E high longer. The block passes that input through a two-flop synchronizer clocked by the fast clock. At each point where E could fall, it decides whether to fall or to keep E high for one more half bus-period (two fast clocks). The E-high time of one bus cycle grows by at most one full bus cycle. E then falls even if memory-ready is still low.

A strobe output marks the fast-clock period just before each possible fall point. A bench or an outside observer can use it to line up the setup rule.

Top module: `quad_eclk_gen`

## Requirements
- R1: `quarter` counts 0,1,2,3 and wraps, advancing once per `clk_4x` cycle except while a stretch holds it at 3. `e_clk` equals bit 1 of `quarter`, so it is high in quarters 2 and 3.
- R2: With `mem_ready` high, `e_clk` is high for exactly 2 `clk_4x` cycles and low for exactly 2, a period of 4.
- R3: If `mem_ready` is low at the `clk_4x` edge where `e_clk` rises, the E-high of that same cycle is stretched. Every stretch adds a multiple of 2 `clk_4x` cycles.
- R4: If `mem_ready` first goes low after the edge where `e_clk` rises, that cycle is not stretched. The stretch begins in the following E-high instead.
- R5: Possible fall points lie 2, 4 and 6 cycles after E rises. The block samples `mem_ready` at the edge 2 cycles before each point. E falls at the first point whose sample is high, so a release that misses one sample falls at the next point.
- R6: E-high never lasts more than 6 `clk_4x` cycles, one bus cycle of extension. At that limit E falls even with `mem_ready` low, and a following cycle may be stretched again.
- R7: The E-low time is always exactly 2 `clk_4x` cycles and is never stretched.
- R8: `sample_stb` is high for one `clk_4x` cycle just before each possible fall point, and never outside quarter 3. An E-high of W cycles therefore holds W/2 strobes, and the last of them sits in its final cycle.
- R9: Synchronous active-high `rst` forces `quarter` = 0, `e_clk` = 0 and `sample_stb` = 0, and aborts any stretch. After release, E rises at the second `clk_4x` edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_4x | input | 1 | Free-running clock at four times the bus rate |
| rst | input | 1 | Synchronous reset, active high |
| mem_ready | input | 1 | Memory ready; low requests E-high stretch |
| e_clk | output | 1 | Bus clock E, registered |
| quarter | output | 2 | Current quarter phase 0..3, registered |
| sample_stb | output | 1 | High in the cycle before a possible E fall |

## Verification
The scoreboard holds the expected width of every E-high pulse. Low windows of 0, 2, 4 and 6 cycles that start before the rise separate no stretch, one half-period, a release that misses a sample, and the cap. A low that starts just after the rise tells a same-cycle stretch from a next-cycle stretch. A low held across two bus cycles shows that the cap applies to each cycle, not once overall. Every pulse also has its strobe count, its last-cycle strobe and the following 2-cycle low checked. A reset in the middle of a stretch shows that the stretch is dropped and timing restarts from quarter 0.

// File: rtl/qclk_pkg.sv
package qclk_pkg;
  typedef logic [1:0] quarter_t;
  // quarter in which E first goes high
  localparam quarter_t Q_RISE = 2'd2;
  // last E-high quarter; a stretch freezes the counter here
  localparam quarter_t Q_HOLD = 2'd3;
endpackage

// File: rtl/rdy_sync.sv
module rdy_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_in,
  output logic d_out
);
  logic [STAGES-1:0] chain_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain_q[0] <= 1'b1;
        else     chain_q[0] <= d_in;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain_q[i] <= 1'b1;
        else     chain_q[i] <= chain_q[i-1];
      end
    end
  end

  assign d_out = chain_q[STAGES-1];
endmodule

// File: rtl/stretch_ctl.sv
module stretch_ctl
  import qclk_pkg::*;
#(
  parameter int CAP_HALVES = 2
) (
  input  logic     clk,
  input  logic     rst,
  input  quarter_t phase,
  input  logic     rdy,
  output logic     hold,
  output logic     stb_next
);
  localparam int CAP_CLK = 2 * CAP_HALVES;
  localparam int ST_W    = $clog2(CAP_CLK + 1);

  logic [ST_W-1:0] st_q;
  logic            below_cap;

  assign below_cap = st_q < ST_W'(CAP_CLK);

  // even count in quarter 3 = a possible fall point; odd = mid half-period
  always_comb begin
    hold = 1'b0;
    if (phase == Q_HOLD) hold = st_q[0] || (!rdy && below_cap);
  end

  // the next cycle is a decision cycle when quarter 3 starts or a half-period completes
  assign stb_next = (phase == Q_RISE) || (hold && st_q[0]);

  always_ff @(posedge clk) begin
    if (rst)       st_q <= '0;
    else if (hold) st_q <= st_q + ST_W'(1);
    else           st_q <= '0;
  end
endmodule

// File: rtl/phase_ctr.sv
module phase_ctr
  import qclk_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     hold,
  input  logic     stb_next,
  output quarter_t phase_q,
  output logic     e_q,
  output logic     stb_q
);
  quarter_t ph_d;

  assign ph_d = hold ? phase_q : quarter_t'(phase_q + 2'd1);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
      e_q     <= 1'b0;
      stb_q   <= 1'b0;
    end else begin
      phase_q <= ph_d;
      e_q     <= ph_d[1];
      stb_q   <= stb_next;
    end
  end

  // R1: outside the hold quarter the phase always steps by one
  a_r1_phase_step: assert property (@(posedge clk) disable iff (rst)
    (phase_q != Q_HOLD) |=> (phase_q == quarter_t'($past(phase_q) + 2'd1)));

  // R7: once E falls it stays low for the next cycle as well
  a_r7_low_two: assert property (@(posedge clk) disable iff (rst)
    $fell(e_q) |=> !e_q);

  // R8: the strobe only appears in the hold quarter
  a_r8_stb_quarter: assert property (@(posedge clk) disable iff (rst)
    stb_q |-> (phase_q == Q_HOLD));
endmodule

// File: rtl/quad_eclk_gen.sv
module quad_eclk_gen #(
  parameter int SYNC_STAGES = 2,
  parameter int CAP_HALVES  = 2
) (
  input  logic       clk_4x,
  input  logic       rst,
  input  logic       mem_ready,
  output logic       e_clk,
  output logic [1:0] quarter,
  output logic       sample_stb
);
  import qclk_pkg::*;

  localparam int MAX_HI = 2 + 2 * CAP_HALVES;
  localparam int HR_W   = $clog2(MAX_HI + 2);

  logic     rdy_s;
  logic     hold;
  logic     stb_next;
  quarter_t phase_q;

  rdy_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk_4x),
    .rst   (rst),
    .d_in  (mem_ready),
    .d_out (rdy_s)
  );

  stretch_ctl #(.CAP_HALVES(CAP_HALVES)) u_stretch (
    .clk      (clk_4x),
    .rst      (rst),
    .phase    (phase_q),
    .rdy      (rdy_s),
    .hold     (hold),
    .stb_next (stb_next)
  );

  phase_ctr u_phase (
    .clk      (clk_4x),
    .rst      (rst),
    .hold     (hold),
    .stb_next (stb_next),
    .phase_q  (phase_q),
    .e_q      (e_clk),
    .stb_q    (sample_stb)
  );

  assign quarter = phase_q;

  // length of the current E-high run, kept for checking only
  logic [HR_W-1:0] hi_run;
  always_ff @(posedge clk_4x) begin
    if (rst)        hi_run <= '0;
    else if (e_clk) hi_run <= hi_run + HR_W'(1);
    else            hi_run <= '0;
  end

  // R6: an E-high never exceeds the capped width
  a_r6_cap: assert property (@(posedge clk_4x) disable iff (rst)
    e_clk |-> (hi_run < HR_W'(MAX_HI)));

  // R5: a ready sample seen at a decision point makes E fall next
  a_r5_release_fall: assert property (@(posedge clk_4x) disable iff (rst)
    (e_clk && sample_stb && rdy_s) |=> !e_clk);
endmodule

// File: tb/quad_eclk_gen_tb.sv
module quad_eclk_gen_tb;
  logic       clk_4x = 1'b0;
  logic       rst;
  logic       mem_ready;
  logic       e_clk;
  logic [1:0] quarter;
  logic       sample_stb;

  int  n_total = 0;
  int  n_fail  = 0;
  bit  mon_en  = 1'b0;
  bit  done    = 1'b0;

  typedef struct {
    int    width;
    string tag;
  } exp_t;
  exp_t sb_q[$];

  always #2 clk_4x = ~clk_4x;

  quad_eclk_gen u_dut (
    .clk_4x     (clk_4x),
    .rst        (rst),
    .mem_ready  (mem_ready),
    .e_clk      (e_clk),
    .quarter    (quarter),
    .sample_stb (sample_stb)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_total++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic expect_pulse(input int w, input string tag);
    exp_t it;
    it.width = w;
    it.tag   = tag;
    sb_q.push_back(it);
  endtask

  // Starts right after an E fall; memory-ready is low for 2*h cycles from the next edge on
  task automatic stretch_cycle(input int h, input string tag);
    expect_pulse(2 + 2 * ((h > 2) ? 2 : h), tag);
    @(negedge clk_4x);
    if (h > 0) begin
      mem_ready = 1'b0;
      repeat (2 * h) @(negedge clk_4x);
      mem_ready = 1'b1;
    end
    @(negedge e_clk);
  endtask

  // R4: low arrives just after the rise, so the stretch lands in the next cycle
  task automatic late_low();
    expect_pulse(2, "R4");
    expect_pulse(4, "R4");
    repeat (3) @(negedge clk_4x);
    mem_ready = 1'b0;
    repeat (4) @(negedge clk_4x);
    mem_ready = 1'b1;
    @(negedge e_clk);
  endtask

  // R6: low held across two bus cycles, each capped separately
  task automatic long_low();
    expect_pulse(6, "R6");
    expect_pulse(6, "R6");
    @(negedge clk_4x);
    mem_ready = 1'b0;
    repeat (12) @(negedge clk_4x);
    mem_ready = 1'b1;
    @(negedge e_clk);
  endtask

  // R9: reset in the middle of a stretch
  task automatic mid_reset();
    @(negedge clk_4x);
    mem_ready = 1'b0;
    repeat (4) @(negedge clk_4x);
    chk(e_clk == 1'b1, "R3", e_clk, 1);
    chk(quarter == 2'd3, "R3", quarter, 3);
    mon_en = 1'b0;
    rst    = 1'b1;
    @(negedge clk_4x);
    chk(e_clk == 1'b0, "R9", e_clk, 0);
    chk(quarter == 2'd0, "R9", quarter, 0);
    chk(sample_stb == 1'b0, "R9", sample_stb, 0);
    mem_ready = 1'b1;
    @(negedge clk_4x);
    expect_pulse(2, "R9");
    rst    = 1'b0;
    mon_en = 1'b1;
    @(negedge e_clk);
  endtask

  // Monitor: samples 1 ns after each rising edge and compares against the scoreboard
  initial begin : monitor
    int hi_cnt, lo_cnt, stb_cnt;
    bit prev_e, prev_stb, seen_fall, started;
    logic [1:0] prev_q;
    exp_t it;
    hi_cnt = 0; lo_cnt = 0; stb_cnt = 0;
    prev_e = 0; prev_stb = 0; seen_fall = 0; started = 0; prev_q = 2'd0;
    forever begin
      @(posedge clk_4x);
      #1;
      if (!mon_en) begin
        hi_cnt = 0; lo_cnt = 0; stb_cnt = 0;
        prev_e = 0; prev_stb = 0; seen_fall = 0; started = 0;
      end else begin
        chk(e_clk == quarter[1], "R1", e_clk, quarter[1]);
        if (started && prev_q != 2'd3)
          chk(quarter == prev_q + 2'd1, "R1", quarter, prev_q + 2'd1);
        if (e_clk && !prev_e) begin
          if (seen_fall) chk(lo_cnt == 2, "R7", lo_cnt, 2);
          lo_cnt = 0;
        end
        if (!e_clk && prev_e) begin
          if (sb_q.size() == 0) begin
            chk(1'b0, "R2", hi_cnt, -1);
          end else begin
            it = sb_q.pop_front();
            chk(hi_cnt == it.width, it.tag, hi_cnt, it.width);
            chk(stb_cnt == it.width / 2, "R8", stb_cnt, it.width / 2);
            chk(prev_stb == 1'b1, "R8", prev_stb, 1);
          end
          seen_fall = 1;
          hi_cnt = 0;
          stb_cnt = 0;
        end
        if (e_clk) begin
          hi_cnt++;
          if (sample_stb) stb_cnt++;
        end else begin
          lo_cnt++;
        end
        prev_e   = e_clk;
        prev_stb = sample_stb;
        prev_q   = quarter;
        started  = 1;
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk_4x);
    if (!done) begin
      n_total++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end

  initial begin : driver
    rst       = 1'b1;
    mem_ready = 1'b1;
    repeat (3) @(negedge clk_4x);
    chk(e_clk == 1'b0, "R9", e_clk, 0);
    chk(quarter == 2'd0, "R9", quarter, 0);
    chk(sample_stb == 1'b0, "R9", sample_stb, 0);
    expect_pulse(2, "R9");
    rst    = 1'b0;
    mon_en = 1'b1;
    @(negedge clk_4x);
    chk(quarter == 2'd1, "R9", quarter, 1);
    chk(e_clk == 1'b0, "R9", e_clk, 0);
    @(negedge clk_4x);
    chk(e_clk == 1'b1, "R9", e_clk, 1);
    @(negedge e_clk);

    stretch_cycle(0, "R2");
    stretch_cycle(0, "R2");
    stretch_cycle(1, "R3");
    stretch_cycle(2, "R5");
    stretch_cycle(3, "R6");
    late_low();
    long_low();
    stretch_cycle(1, "R3");
    mid_reset();
    stretch_cycle(0, "R2");

    @(negedge clk_4x);
    chk(sb_q.size() == 0, "R2", sb_q.size(), 0);
    mon_en = 1'b0;
    done   = 1'b1;
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule